// File: doc/BRIEF.md
# DDR2 Precharge Power-Down Sequencer

This block sits between the request arbiter of a DDR2 memory controller and the clock-enable pin of the memory. A single control input asks for precharge power-down. The block does not drop clock-enable straight away. It first waits until the access in flight, and every access queued behind it, has finished. This includes accesses that arrive while it is waiting. Once the request path is empty, it raises a block signal toward the arbiter, waits a programmable entry delay, and then drives clock-enable low. It reports a status flag only when clock-enable is actually low.

Clearing the control input ends the power-down. Clock-enable stays low for at least the programmed minimum low time. After clock-enable rises, the arbiter stays blocked for the longest of three exit recovery counts. If the control input is cleared before clock-enable has fallen, the entry is abandoned and clock-enable never toggles.

The memory gets no refresh in this mode. For that reason a cycle counter runs for as long as clock-enable is low. When the counter reaches a programmable limit, the block raises a warning. Software normally sets this limit to about nine refresh intervals in cycles.

Top module: `ddr_pdn_seq`

## Requirements
- R1: During and right after reset, `cke` is 1 and `req_block`, `pd_status` and `refresh_warn` are 0.
- R2: While `pd_req` is 0 and no sequence is in progress, the outputs stay at their idle values whatever `acc_busy` and `acc_pending` do.
- R3: After `pd_req` rises, `req_block` stays 0 and `cke` stays 1 while `acc_busy` or `acc_pending` is 1. `req_block` rises after the first clock edge that finds both low, and no earlier than the second edge after the request.
- R4: `cke` falls after `req_block` has been high with `cke` high for exactly max(`cfg_t_entry`,1) cycles.
- R5: `pd_status` is 1 in exactly the cycles in which `cke` is 0.
- R6: `cke` stays 0 while `pd_req` is 1. If `pd_req` is cleared in the P-th low cycle, the low time is max(P, `cfg_t_cke`) cycles.
- R7: After `cke` rises, `req_block` stays 1 for exactly max(`cfg_t_xp`, `cfg_t_xard`, `cfg_t_xards`, 1) cycles and then falls.
- R8: `req_block` stays 1 without a gap from the end of the drain until the exit recovery ends. It covers every cycle in which `cke` is 0.
- R9: `refresh_warn` is 1 only while `pd_status` is 1. It is 1 from the (L+1)-th low cycle onward, where L = `cfg_pd_limit` ≥ 1, and returns to 0 on exit.
- R10: If `pd_req` is cleared while draining or during the entry delay, `cke` never falls and `req_block` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_req | input | 1 | Software power-down request (1 = enter, 0 = leave / no effect) |
| acc_busy | input | 1 | An access is in progress |
| acc_pending | input | 1 | One or more accesses are queued |
| cfg_t_entry | input | CNT_W | Entry delay in cycles from block to clock-enable low |
| cfg_t_cke | input | CNT_W | Minimum clock-enable low time in cycles |
| cfg_t_xp | input | CNT_W | Exit recovery count, first |
| cfg_t_xard | input | CNT_W | Exit recovery count, second |
| cfg_t_xards | input | CNT_W | Exit recovery count, third |
| cfg_pd_limit | input | LIM_W | Low-time cycle count that triggers the refresh warning |
| cke | output | 1 | Memory clock-enable |
| req_block | output | 1 | Holds off new requests at the arbiter |
| pd_status | output | 1 | Device is in power-down |
| refresh_warn | output | 1 | Power-down has run long enough to endanger refresh |

## Verification
The bench builds the block with CNT_W = 4 and LIM_W = 6. This keeps every delay small, so a full entry–exit sequence lasts only a few tens of cycles. Several hundred sequences can therefore be run. They sweep the entry delay, the minimum low time, the release point of the request, the drain length and the source that holds the drain (busy or pending). They also rotate which of the three recovery counts is largest, and step the warning limit around the low time. Each sequence is checked against closed-form expected lengths. The zero-valued counts and the two abandon points are included in reach.

// File: rtl/pdn_pkg.sv
// Package: shared types of the precharge power-down sequencer.
package pdn_pkg;

    // Sequencer phases.
    typedef enum logic [2:0] {
        PD_IDLE  = 3'd0,  // normal operation
        PD_DRAIN = 3'd1,  // waiting for in-flight and queued accesses
        PD_ENTER = 3'd2,  // requests blocked, entry delay running
        PD_DOWN  = 3'd3,  // clock-enable low
        PD_LEAVE = 3'd4   // clock-enable high, exit recovery running
    } pd_state_t;

    // Number of exit recovery counts that are combined.
    localparam int unsigned EXIT_TERMS = 3;

endpackage : pdn_pkg

// File: rtl/pdn_span_timer.sv
// Module: pdn_span_timer
// Loadable down-counter that times the entry delay and the exit recovery.
// A load with value V makes the phase that follows last max(V,1) cycles:
// `expired` is high in that phase's last cycle.
// Assumes load is pulsed only on the edge that enters the timed phase.
module pdn_span_timer #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] remain_q;

    // Purpose: load a new span or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    // Purpose: flag the last cycle of the span (a zero load lasts one cycle).
    always_comb begin
        expired = (remain_q <= W'(1));
    end

endmodule : pdn_span_timer

// File: rtl/pdn_dwell_mon.sv
// Module: pdn_dwell_mon
// Counts the cycles spent with clock-enable low. From this count it derives
// whether the minimum low time has been met and whether the refresh-risk
// warning must be raised. The warning is sticky for as long as power-down lasts.
// Assumes LIM_W >= CNT_W and a limit of at least 1.
module pdn_dwell_mon #(
    parameter int unsigned CNT_W = 4,
    parameter int unsigned LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_pd,
    input  logic [CNT_W-1:0] cfg_t_cke,
    input  logic [LIM_W-1:0] cfg_pd_limit,
    output logic             cke_min_met,
    output logic             warn
);

    localparam int unsigned SUM_W = LIM_W + 1;

    logic [LIM_W-1:0] dwell_q;     // completed low cycles
    logic             warn_q;
    logic [SUM_W-1:0] this_cycle;  // index of the current low cycle, 1-based
    logic [SUM_W-1:0] tcke_ext;
    logic [SUM_W-1:0] limit_ext;

    // Purpose: widen operands so that the comparisons cannot wrap.
    always_comb begin
        this_cycle = {1'b0, dwell_q} + SUM_W'(1);
        tcke_ext   = SUM_W'(cfg_t_cke);
        limit_ext  = {1'b0, cfg_pd_limit};
    end

    // Purpose: count low cycles while in power-down (saturating), clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dwell_q <= '0;
        end else if (!in_pd) begin
            dwell_q <= '0;
        end else if (dwell_q != {LIM_W{1'b1}}) begin
            dwell_q <= dwell_q + 1'b1;
        end
    end

    // Purpose: set the warning once the limit-th low cycle completes; clear on exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warn_q <= 1'b0;
        end else if (!in_pd) begin
            warn_q <= 1'b0;
        end else if (this_cycle >= limit_ext) begin
            warn_q <= 1'b1;
        end
    end

    // Purpose: drive the minimum-low flag and gate the warning to power-down.
    always_comb begin
        cke_min_met = in_pd && (this_cycle >= tcke_ext);
        warn        = warn_q && in_pd;
    end

endmodule : pdn_dwell_mon

// File: rtl/pdn_ctrl_fsm.sv
// Module: pdn_ctrl_fsm
// Phase controller of the sequencer. Entry first drains accesses, then
// blocks requests, then lowers clock-enable. Exit is gated by the minimum
// low time and by the recovery span. Abandons entry if the request is
// withdrawn before clock-enable falls.
// Assumes the span timer and dwell monitor respond in the cycle after a load.
module pdn_ctrl_fsm
    import pdn_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pd_req,
    input  logic      acc_busy,
    input  logic      acc_pending,
    input  logic      span_expired,
    input  logic      cke_min_met,
    output logic      load_entry,
    output logic      load_exit,
    output pd_state_t state
);

    pd_state_t state_d;
    logic      path_empty;

    // Purpose: the drain is done once nothing is in flight or queued.
    always_comb begin
        path_empty = !acc_busy && !acc_pending;
    end

    // Purpose: next-phase decision and timer load strobes.
    always_comb begin
        state_d    = state;
        load_entry = 1'b0;
        load_exit  = 1'b0;
        unique case (state)
            PD_IDLE: begin
                if (pd_req) state_d = PD_DRAIN;
            end
            PD_DRAIN: begin
                if (!pd_req) begin
                    state_d = PD_IDLE;
                end else if (path_empty) begin
                    state_d    = PD_ENTER;
                    load_entry = 1'b1;
                end
            end
            PD_ENTER: begin
                if (!pd_req) begin
                    state_d = PD_IDLE;
                end else if (span_expired) begin
                    state_d = PD_DOWN;
                end
            end
            PD_DOWN: begin
                if (!pd_req && cke_min_met) begin
                    state_d   = PD_LEAVE;
                    load_exit = 1'b1;
                end
            end
            PD_LEAVE: begin
                if (span_expired) state_d = PD_IDLE;
            end
            default: state_d = PD_IDLE;
        endcase
    end

    // Purpose: phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PD_IDLE;
        else        state <= state_d;
    end

endmodule : pdn_ctrl_fsm

// File: rtl/ddr_pdn_seq.sv
// Module: ddr_pdn_seq (top)
// DDR2 precharge power-down sequencer. It ties together the phase controller,
// the span timer and the dwell monitor. It folds the exit recovery counts
// into their maximum and decodes the pin-level outputs from the phase.
// Assumes LIM_W >= CNT_W and that the arbiter honours req_block in the next cycle.
module ddr_pdn_seq
    import pdn_pkg::*;
#(
    parameter int unsigned CNT_W = 4,
    parameter int unsigned LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_req,
    input  logic             acc_busy,
    input  logic             acc_pending,
    input  logic [CNT_W-1:0] cfg_t_entry,
    input  logic [CNT_W-1:0] cfg_t_cke,
    input  logic [CNT_W-1:0] cfg_t_xp,
    input  logic [CNT_W-1:0] cfg_t_xard,
    input  logic [CNT_W-1:0] cfg_t_xards,
    input  logic [LIM_W-1:0] cfg_pd_limit,
    output logic             cke,
    output logic             req_block,
    output logic             pd_status,
    output logic             refresh_warn
);

    pd_state_t        state;
    logic             load_entry;
    logic             load_exit;
    logic             span_expired;
    logic             cke_min_met;
    logic             in_pd;
    logic [CNT_W-1:0] span_val;
    logic [CNT_W-1:0] exit_terms [EXIT_TERMS];
    logic [CNT_W-1:0] exit_run   [EXIT_TERMS+1];

    // Purpose: gather the exit recovery counts for the max reduction.
    always_comb begin
        exit_terms[0] = cfg_t_xp;
        exit_terms[1] = cfg_t_xard;
        exit_terms[2] = cfg_t_xards;
    end

    assign exit_run[0] = '0;

    // Running maximum over the recovery counts.
    for (genvar i = 0; i < EXIT_TERMS; i++) begin : g_exit_max
        assign exit_run[i+1] = (exit_terms[i] > exit_run[i]) ? exit_terms[i] : exit_run[i];
    end

    // Purpose: choose which span the timer loads.
    always_comb begin
        span_val = load_exit ? exit_run[EXIT_TERMS] : cfg_t_entry;
    end

    pdn_ctrl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .pd_req       (pd_req),
        .acc_busy     (acc_busy),
        .acc_pending  (acc_pending),
        .span_expired (span_expired),
        .cke_min_met  (cke_min_met),
        .load_entry   (load_entry),
        .load_exit    (load_exit),
        .state        (state)
    );

    pdn_span_timer #(.W(CNT_W)) u_span (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_entry || load_exit),
        .load_val (span_val),
        .expired  (span_expired)
    );

    pdn_dwell_mon #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_dwell (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_pd        (in_pd),
        .cfg_t_cke    (cfg_t_cke),
        .cfg_pd_limit (cfg_pd_limit),
        .cke_min_met  (cke_min_met),
        .warn         (refresh_warn)
    );

    // Purpose: decode pin-level outputs from the phase register.
    always_comb begin
        in_pd     = (state == PD_DOWN);
        cke       = !in_pd;
        pd_status = in_pd;
        req_block = (state == PD_ENTER) || (state == PD_DOWN) || (state == PD_LEAVE);
    end

endmodule : ddr_pdn_seq

// File: rtl/pdn_seq_checker.sv
// Module: pdn_seq_checker
// Port-level temporal properties of ddr_pdn_seq, attached through bind.
module pdn_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic pd_req,
    input logic acc_busy,
    input logic acc_pending,
    input logic cke,
    input logic req_block,
    input logic pd_status,
    input logic refresh_warn
);

    // R2: with no request and no sequence running, the block stays idle.
    assert_idle_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd_req && !req_block && cke) |=> (!req_block && cke));

    // R3: requests are not blocked while an access is in flight or queued.
    assert_no_block_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_block && (acc_busy || acc_pending)) |=> !req_block);

    // R8: clock-enable only falls with requests already blocked.
    assert_cke_fall_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> ($past(req_block) && req_block));

    // R7: clock-enable rising starts a blocked recovery span.
    assert_exit_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> req_block);

    // R6: power-down holds while the request stays set.
    assert_hold_in_pd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_status && pd_req) |=> pd_status);

    // R5: status is reported only with clock-enable low.
    assert_status_cke_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pd_status |-> !cke);

    // R9: the warning appears only during power-down.
    assert_warn_in_pd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_warn |-> pd_status);

    // R10: withdrawing the request before power-down clears the block.
    assert_abandon_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd_req && req_block && cke && !$past(pd_status) && $past(pd_req)) |=> !req_block);

endmodule : pdn_seq_checker

bind ddr_pdn_seq pdn_seq_checker u_pdn_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pd_req       (pd_req),
    .acc_busy     (acc_busy),
    .acc_pending  (acc_pending),
    .cke          (cke),
    .req_block    (req_block),
    .pd_status    (pd_status),
    .refresh_warn (refresh_warn)
);

// File: tb/ddr_pdn_seq_test.sv
// Bench for ddr_pdn_seq: sweeps full entry/exit sequences and checks
// closed-form phase lengths; also covers reset, idle and abandon cases.
module ddr_pdn_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 4;
    localparam int LIM_W = 6;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             pd_req;
    logic             acc_busy;
    logic             acc_pending;
    logic [CNT_W-1:0] cfg_t_entry;
    logic [CNT_W-1:0] cfg_t_cke;
    logic [CNT_W-1:0] cfg_t_xp;
    logic [CNT_W-1:0] cfg_t_xard;
    logic [CNT_W-1:0] cfg_t_xards;
    logic [LIM_W-1:0] cfg_pd_limit;
    logic             cke;
    logic             req_block;
    logic             pd_status;
    logic             refresh_warn;

    int n_checks = 0;
    int n_fail   = 0;
    bit reported = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr_pdn_seq #(.CNT_W(CNT_W), .LIM_W(LIM_W)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pd_req       (pd_req),
        .acc_busy     (acc_busy),
        .acc_pending  (acc_pending),
        .cfg_t_entry  (cfg_t_entry),
        .cfg_t_cke    (cfg_t_cke),
        .cfg_t_xp     (cfg_t_xp),
        .cfg_t_xard   (cfg_t_xard),
        .cfg_t_xards  (cfg_t_xards),
        .cfg_pd_limit (cfg_pd_limit),
        .cke          (cke),
        .req_block    (req_block),
        .pd_status    (pd_status),
        .refresh_warn (refresh_warn)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // One full sequence; inputs change and outputs are sampled at negedges.
    task automatic run_seq(input int te, input int tc, input int p, input int d,
                           input bit use_pend, input int xp, input int xa,
                           input int xs, input int lim);
        int phase = 0;
        int pre = 0, ent = 0, low = 0, ext = 0;
        int warn_first = 0;
        int bad_drain = 0, bad_gap = 0, bad_stat = 0, bad_warn = 0;
        int k = 0;
        cfg_t_entry  = CNT_W'(te);
        cfg_t_cke    = CNT_W'(tc);
        cfg_t_xp     = CNT_W'(xp);
        cfg_t_xard   = CNT_W'(xa);
        cfg_t_xards  = CNT_W'(xs);
        cfg_pd_limit = LIM_W'(lim);
        pd_req       = 1'b1;
        acc_busy     = !use_pend && (d > 0);
        acc_pending  = use_pend && (d > 0);
        while (phase != 4 && k < 200) begin
            @(negedge clk);
            k++;
            if (pd_status != !cke) bad_stat++;
            if (refresh_warn && !pd_status) bad_warn++;
            case (phase)
                0: begin
                    if (!cke) bad_drain++;
                    if (req_block) begin phase = 1; ent = 1; end
                    else pre++;
                end
                1: begin
                    if (!cke) begin phase = 2; low = 1; end
                    else if (req_block) ent++;
                    else bad_gap++;
                end
                2: begin
                    if (cke) begin
                        phase = 3; ext = 1;
                        if (!req_block) bad_gap++;
                    end else low++;
                end
                3: begin
                    if (!req_block) phase = 4;
                    else ext++;
                end
                default: ;
            endcase
            if (phase == 2 && !cke) begin
                if (!req_block) bad_gap++;
                if (refresh_warn && warn_first == 0) warn_first = low;
                if (warn_first != 0 && !refresh_warn) bad_warn++;
                if (low == p) pd_req = 1'b0;
            end
            if (k == d) begin acc_busy = 1'b0; acc_pending = 1'b0; end
        end
        check(pre == imax(d, 1) && bad_drain == 0, "R3 drain length", pre, imax(d, 1));
        check(ent == imax(te, 1), "R4 entry delay", ent, imax(te, 1));
        check(low == imax(p, tc), "R6 low time", low, imax(p, tc));
        check(ext == imax(imax(xp, xa), imax(xs, 1)), "R7 exit recovery", ext,
              imax(imax(xp, xa), imax(xs, 1)));
        check(bad_gap == 0, "R8 block continuity", bad_gap, 0);
        check(bad_stat == 0, "R5 status tracks cke", bad_stat, 0);
        check(warn_first == ((imax(p, tc) >= lim + 1) ? lim + 1 : 0) && bad_warn == 0,
              "R9 warning onset", warn_first, (imax(p, tc) >= lim + 1) ? lim + 1 : 0);
        @(negedge clk);
        check(!refresh_warn && cke && !req_block, "R9 warning cleared on exit",
              int'(refresh_warn), 0);
    endtask

    // Withdraw the request during the drain (stage 0) or the entry delay (stage 1).
    task automatic run_abandon(input int stage);
        int cke_lows = 0;
        cfg_t_entry = CNT_W'(6);
        pd_req      = 1'b1;
        acc_busy    = (stage == 0);
        acc_pending = 1'b0;
        repeat (stage == 0 ? 3 : 4) @(negedge clk);
        check(req_block == (stage == 1), "R10 phase before withdraw", int'(req_block),
              int'(stage == 1));
        pd_req = 1'b0;
        acc_busy = 1'b0;
        @(negedge clk);
        check(!req_block, "R10 block cleared after withdraw", int'(req_block), 0);
        repeat (10) begin
            @(negedge clk);
            if (!cke || req_block) cke_lows++;
        end
        check(cke_lows == 0, "R10 cke never toggles", cke_lows, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        report();
        $finish;
    end

    initial begin
        int idle_bad = 0;
        rst_n = 1'b0; pd_req = 1'b0; acc_busy = 1'b0; acc_pending = 1'b0;
        cfg_t_entry = '0; cfg_t_cke = '0; cfg_t_xp = '0; cfg_t_xard = '0;
        cfg_t_xards = '0; cfg_pd_limit = LIM_W'(4);
        repeat (3) @(negedge clk);
        check(cke && !req_block && !pd_status && !refresh_warn, "R1 reset outputs",
              {28'd0, cke, req_block, pd_status, refresh_warn}, 8);
        rst_n = 1'b1;
        @(negedge clk);
        check(cke && !req_block && !pd_status && !refresh_warn, "R1 after release",
              {28'd0, cke, req_block, pd_status, refresh_warn}, 8);

        // R2: access activity without a request has no effect.
        for (int i = 0; i < 16; i++) begin
            acc_busy = i[0];
            acc_pending = i[1];
            @(negedge clk);
            if (!cke || req_block || pd_status || refresh_warn) idle_bad++;
        end
        acc_busy = 1'b0; acc_pending = 1'b0;
        check(idle_bad == 0, "R2 idle without request", idle_bad, 0);

        // R3: a pending queue alone holds off entry.
        pd_req = 1'b1; acc_pending = 1'b1;
        repeat (12) @(negedge clk);
        check(!req_block && cke, "R3 pending holds entry", int'(req_block), 0);
        pd_req = 1'b0; acc_pending = 1'b0;
        repeat (2) @(negedge clk);

        run_abandon(0);
        run_abandon(1);

        // Sweep of full sequences (R3..R9).
        for (int te = 0; te < 3; te++)
            for (int tc = 0; tc < 4; tc++)
                for (int p = 1; p < 4; p++)
                    for (int d = 0; d < 3; d++)
                        for (int r = 0; r < 4; r++) begin
                            int xp = (r == 0) ? 5 : r;
                            int xa = (r == 1) ? 4 : (r + 1) % 3;
                            int xs = (r == 2) ? 6 : 0;
                            run_seq(te, tc, p, d, bit'((d + r) % 2), xp, xa, xs,
                                    (te + p + r) % 4 + 1);
                        end
        report();
        $finish;
    end

endmodule : ddr_pdn_seq_test